// File: doc/BRIEF.md
# APB Requester with Chained Transfers

This block is the requesting side of an APB link toward one peripheral. Commands come in on a valid/ready port. Each command carries a direction, an address and write data. The block runs each command through the usual three phases: idle, a one-cycle setup phase, and an access phase. During the setup phase the select is high and the enable is low. The access phase lasts until the peripheral reports ready.

When the access phase completes, the block returns the read data and the error flag on a response port. The response port raises a one-cycle valid strobe. It has no back-pressure.

Only one transfer is in flight at any time. The command port opens in two places: in the idle phase, and in the cycle in which the access phase completes. If a command is accepted in the completing cycle, the block moves straight into a new setup phase and keeps the select high. It does not drop back to idle between the two transfers. At full rate this gives one transfer every two cycles.

Top module: `apb_chain_requester`

## Requirements
- R1: While `presetn` is low, `psel`, `penable` and `rsp_valid` are low and `cmd_ready` is high.
- R2: `cmd_ready` is high only in the idle phase (`psel` low) or in an access cycle in which `pready` is high. A command accepted while idle gives `psel`=1, `penable`=0 in the next cycle, with `paddr`, `pwrite` (1 = write) and `pwdata` equal to the accepted command.
- R3: The setup phase lasts exactly one cycle. It is followed by `psel`=1, `penable`=1.
- R4: While `penable` is high and `pready` is low, the access phase continues. In that case `paddr`, `pwrite` and `pwdata` do not change and `cmd_ready` is low.
- R5: A transfer completes only in a cycle with `penable` and `pready` both high. Exactly one `rsp_valid` pulse follows each completion, in the next cycle.
- R6: For a read, `rsp_rdata` equals `prdata` as sampled in the completing cycle. For a write, `rsp_rdata` is zero.
- R7: `rsp_err` equals `pslverr` as sampled in the completing cycle.
- R8: If a command is accepted in the completing cycle, the next cycle has `psel`=1 and `penable`=0, and carries the new command's address, direction and data.
- R9: If no command is accepted in the completing cycle, the next cycle has `psel`=0 and `penable`=0.
- R10: `penable` is never high while `psel` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| rsp_err | output | 1 | Peripheral error flag of the transfer |
| psel | output | 1 | Peripheral select |
| penable | output | 1 | Access phase enable |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| prdata | input | DATA_W | Bus read data |
| pready | input | 1 | Peripheral ready / wait-state control |
| pslverr | input | 1 | Peripheral error |

## Verification
The hardest case to reach is the chained handover. A command must be waiting exactly in a cycle where the access phase completes, and that cycle's position depends on the random wait states. The stimulus therefore holds a pending command on the port across the whole access phase, so that the only place it can be taken is the completing edge. One phase of the run keeps commands always valid and ready always high, which forces every transfer to chain. Other phases mix long wait-state streaks with sparse commands, so that the paths back to idle and the error responses are covered too.

// File: rtl/apbreq_pkg.sv
package apbreq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETUP  = 2'd1,
      ST_ACCESS = 2'd2
   } apbreq_state_e;
endpackage

// File: rtl/apbreq_fsm.sv
module apbreq_fsm
   import apbreq_pkg::*;
(
   input  logic          clk,
   input  logic          presetn,
   input  logic          cmd_valid,
   input  logic          pready,
   output apbreq_state_e state,
   output logic          cmd_ready,
   output logic          accept,
   output logic          done
);
   apbreq_state_e state_q, state_d;

   always_comb begin
      done      = (state_q == ST_ACCESS) && pready;
      cmd_ready = (state_q == ST_IDLE) || done;
      accept    = cmd_ready && cmd_valid;
      state_d   = state_q;
      unique case (state_q)
         ST_IDLE:   state_d = accept ? ST_SETUP : ST_IDLE;
         ST_SETUP:  state_d = ST_ACCESS;
         ST_ACCESS: begin
            if (done) state_d = accept ? ST_SETUP : ST_IDLE; // R8 / R9
         end
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge presetn) begin
      if (!presetn) state_q <= ST_IDLE;
      else          state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/apbreq_cmd_hold.sv
module apbreq_cmd_hold #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              presetn,
   input  logic              load,
   input  logic              in_write,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_wdata,
   output logic              out_write,
   output logic [ADDR_W-1:0] out_addr,
   output logic [DATA_W-1:0] out_wdata
);
   always_ff @(posedge clk or negedge presetn) begin
      if (!presetn) begin
         out_write <= 1'b0;
         out_addr  <= '0;
         out_wdata <= '0;
      end else if (load) begin
         out_write <= in_write;
         out_addr  <= in_addr;
         out_wdata <= in_wdata;
      end
   end
endmodule

// File: rtl/apbreq_rsp.sv
module apbreq_rsp #(
   parameter int DATA_W          = 32,
   parameter bit ZERO_WRITE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              presetn,
   input  logic              done,
   input  logic              cur_write,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err
);
   logic [DATA_W-1:0] data_sel;

   generate
      if (ZERO_WRITE_DATA) begin : g_zero_wr
         assign data_sel = cur_write ? '0 : prdata;
      end else begin : g_pass_wr
         logic unused_wr;
         assign unused_wr = cur_write;
         assign data_sel  = prdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge presetn) begin
      if (!presetn) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
      end else begin
         rsp_valid <= done;
         if (done) begin
            rsp_rdata <= data_sel;
            rsp_err   <= pslverr;
         end
      end
   end
endmodule

// File: rtl/apb_chain_requester.sv
module apb_chain_requester
   import apbreq_pkg::*;
#(
   parameter int ADDR_W          = 16,
   parameter int DATA_W          = 32,
   parameter bit HOLD_BUS_IDLE   = 1'b1,
   parameter bit ZERO_WRITE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              presetn,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              psel,
   output logic              penable,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pready,
   input  logic              pslverr
);
   localparam int DATA_BYTES = DATA_W / 8;

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must be within 1..64");
      end
      if (DATA_W < 8 || DATA_BYTES * 8 != DATA_W) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
   endgenerate

   apbreq_state_e     state;
   logic              accept, done;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   apbreq_fsm u_fsm (
      .clk       (clk),
      .presetn   (presetn),
      .cmd_valid (cmd_valid),
      .pready    (pready),
      .state     (state),
      .cmd_ready (cmd_ready),
      .accept    (accept),
      .done      (done)
   );

   apbreq_cmd_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .presetn   (presetn),
      .load      (accept),
      .in_write  (cmd_write),
      .in_addr   (cmd_addr),
      .in_wdata  (cmd_wdata),
      .out_write (pwrite),
      .out_addr  (addr_q),
      .out_wdata (wdata_q)
   );

   apbreq_rsp #(.DATA_W(DATA_W), .ZERO_WRITE_DATA(ZERO_WRITE_DATA)) u_rsp (
      .clk       (clk),
      .presetn   (presetn),
      .done      (done),
      .cur_write (pwrite),
      .prdata    (prdata),
      .pslverr   (pslverr),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .rsp_err   (rsp_err)
   );

   assign psel    = (state != ST_IDLE);
   assign penable = (state == ST_ACCESS);

   generate
      if (HOLD_BUS_IDLE) begin : g_hold_bus
         assign paddr  = addr_q;
         assign pwdata = wdata_q;
      end else begin : g_gate_bus
         assign paddr  = psel ? addr_q  : '0;
         assign pwdata = psel ? wdata_q : '0;
      end
   endgenerate
endmodule

// File: rtl/apbreq_chk.sv
module apbreq_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              presetn,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              rsp_valid,
   input logic              psel,
   input logic              penable,
   input logic [ADDR_W-1:0] paddr,
   input logic              pwrite,
   input logic [DATA_W-1:0] pwdata,
   input logic              pready
);
   AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!presetn)
      cmd_ready |-> (!psel || (penable && pready))); // R2
   AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!presetn)
      (psel && !penable) |=> (psel && penable)); // R3
   AST_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!presetn)
      (penable && !pready) |=> (penable && $stable(paddr) && $stable(pwrite) && $stable(pwdata))); // R4
   AST_RSP_AFTER_DONE: assert property (@(posedge clk) disable iff (!presetn)
      (penable && pready) |=> rsp_valid); // R5
   AST_RSP_ONLY_AFTER_DONE: assert property (@(posedge clk) disable iff (!presetn)
      rsp_valid |-> $past(penable && pready)); // R5
   AST_CHAIN_SETUP: assert property (@(posedge clk) disable iff (!presetn)
      (penable && pready && cmd_valid) |=> (psel && !penable)); // R8
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!presetn)
      (penable && pready && !cmd_valid) |=> (!psel && !penable)); // R9
   AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!presetn)
      penable |-> psel); // R10
endmodule

bind apb_chain_requester apbreq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/apb_chain_requester_tb.sv
module apb_chain_requester_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int RUN_CYCLES = 6000;

   logic          clk = 1'b0;
   logic          presetn = 1'b0;
   logic          cmd_valid = 1'b0, cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_ready, rsp_valid, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic          psel, penable, pwrite;
   logic [AW-1:0] paddr;
   logic [DW-1:0] pwdata;
   logic [DW-1:0] prdata = '0;
   logic          pready = 1'b0, pslverr = 1'b0;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   apb_chain_requester #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_rdata(input logic wr, input logic [DW-1:0] rd);
      return wr ? '0 : rd;
   endfunction

   function automatic bit roll(input int pct);
      return ($urandom % 100) < pct;
   endfunction

   // model: 0 idle, 1 setup, 2 access
   int            m_state = 0;
   logic          c_write = 0;
   logic [AW-1:0] c_addr = '0;
   logic [DW-1:0] c_wdata = '0;
   logic          e_rv = 0, e_err = 0;
   logic [DW-1:0] e_rd = '0;
   int            accepted = 0, completed = 0, chains = 0;

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'h1f2e3d4c);
      repeat (3) begin
         @(negedge clk);
         check("R1", "psel in reset", psel, 0);
         check("R1", "penable in reset", penable, 0);
         check("R1", "rsp_valid in reset", rsp_valid, 0);
         check("R1", "cmd_ready in reset", cmd_ready, 1);
      end
      presetn = 1'b1;
      for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
         int rdy_pct, cmd_pct, err_pct;
         logic acc, dn;
         @(negedge clk);
         // phase selection: directed corners then random mixes
         if (cyc < 400)       begin rdy_pct = 100; cmd_pct = 100; err_pct = 0;  end // R8 full-rate chain
         else if (cyc < 1200) begin rdy_pct = 15;  cmd_pct = 100; err_pct = 20; end // R4 long waits
         else if (cyc < 2000) begin rdy_pct = 60;  cmd_pct = 10;  err_pct = 50; end // R9 sparse
         else                 begin rdy_pct = 50;  cmd_pct = 50;  err_pct = 30; end
         // observe registered outputs
         check("R10", "psel", psel, m_state != 0);
         check("R3", "penable", penable, m_state == 2);
         if (m_state != 0) begin
            check("R2", "paddr", paddr, c_addr);
            check("R2", "pwrite", pwrite, c_write);
            check("R4", "pwdata", pwdata, c_wdata);
         end
         check("R5", "rsp_valid", rsp_valid, e_rv);
         if (e_rv) begin
            check("R6", "rsp_rdata", rsp_rdata, e_rd);
            check("R7", "rsp_err", rsp_err, e_err);
         end
         // drive peripheral and command side
         pready  = roll(rdy_pct);
         prdata  = $urandom;
         pslverr = roll(err_pct);
         if (!cmd_valid && roll(cmd_pct)) begin
            cmd_valid = 1'b1;
            cmd_write = $urandom % 2;
            cmd_addr  = $urandom;
            cmd_wdata = $urandom;
         end
         #1;
         dn = (m_state == 2) && pready;
         check(dn ? "R8" : "R4", "cmd_ready", cmd_ready, (m_state == 0) || dn);
         acc = cmd_valid && ((m_state == 0) || dn);
         e_rv = dn;
         if (dn) begin
            e_rd  = exp_rdata(c_write, prdata);
            e_err = pslverr;
            completed++;
         end
         if (m_state == 1) m_state = 2;
         else if (m_state == 0 || dn) begin
            if (dn && acc) chains++;
            m_state = acc ? 1 : 0;
         end
         if (acc) begin
            c_write = cmd_write; c_addr = cmd_addr; c_wdata = cmd_wdata;
            accepted++;
         end
         @(posedge clk);
         #1;
         if (acc) cmd_valid = 1'b0;
      end
      check("R5", "transfers completed vs accepted (<=1 in flight)", accepted - completed <= 1, 1);
      check("R8", "chained handovers seen", chains > 100, 1);
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule